// File: doc/BRIEF.md
# Storage Card Sector Write Sequencer

This block writes one 512-byte sector at a time to an ATA-style storage card that is wired in True IDE mode, using programmed-I/O register cycles only. A one-cycle `start` pulse together with a 28-bit logical block address launches a sector. The sequencer polls the card's status register until the card is idle. It then loads the transfer count, the four address registers and the write command. It polls again until the card asks for data, and finally streams 256 sixteen-bit words from a valid/ready input into the card's data register.

Every register access runs through one bus-cycle engine. Each access has an address setup phase, an active-low strobe phase and a recovery phase. The three lengths come from run-time inputs in clock cycles, so the same logic can start with slow, safe timing and later be tightened for faster PIO modes. A status word with the error bit set, or a polling phase that runs too long, parks the sequencer in a fault state. The fault state raises `error` and stays until reset.

Top module: `cf_sector_writer`

## Requirements
- R1: While and right after reset, `ata_cs_n`, `ata_rd_n` and `ata_wr_n` are high, and `ata_oe`, `s_ready`, `busy`, `done` and `error` are low.
- R2: A `start` accepted while idle first reads the status register (offset 7). No register write is made until a status read returns busy (bit 7) = 0, data request (bit 3) = 0 and error (bit 0) = 0. Any other non-busy, non-error status causes the read to be repeated.
- R3: After that status read, exactly these writes follow in this order: 1 to offset 2 (count), LBA[7:0] to offset 3, LBA[15:8] to offset 4, LBA[23:16] to offset 5, 0xE0 | LBA[27:24] to offset 6, and 0x30 to offset 7. The upper data byte is zero, and the LBA is the value captured with the accepted `start`.
- R4: After the command, status is read until busy = 0 and data request = 1. Then exactly WORDS (default 256) writes to offset 0 carry the stream words in arrival order.
- R5: `s_ready` is high only in the data phase, after the data-request status and while no bus cycle is running. Words offered at any other time are not taken.
- R6: Every bus cycle holds chip select low and the address valid for max(t_setup,1) cycles before the strobe falls. The strobe stays low for max(t_pulse,1) cycles. Chip select and the address then stay for max(t_recov,1) more cycles, and the address does not change while chip select is low.
- R7: A status read with busy = 0 and error = 1 in either polling phase sets `error`, clears `busy` and ends all further bus activity until reset. Error bits seen while busy = 1 are ignored.
- R8: If a polling phase lasts TIMEOUT (default 4096) cycles without success, `error` is set, with the same effect as R7.
- R9: `busy` is high from the cycle after an accepted `start` until the sector completes. `done` is high for exactly one cycle, during the last data write's final recovery cycle, and `busy` is low in the following cycle.
- R10: `start` is ignored while a sector is in progress and while `error` is set. It changes neither the bus traffic nor the captured LBA.
- R11: `ata_oe` is high whenever the write strobe is low and low whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse to begin one sector write |
| lba | input | 28 | Logical block address, captured with `start` |
| t_setup | input | TW | Address setup length in cycles (0 treated as 1) |
| t_pulse | input | TW | Strobe low length in cycles (0 treated as 1) |
| t_recov | input | TW | Recovery/hold length in cycles (0 treated as 1) |
| s_valid | input | 1 | Stream word valid |
| s_data | input | DW | Stream word |
| s_ready | output | 1 | Stream word accepted when high with `s_valid` |
| busy | output | 1 | Sector in progress |
| done | output | 1 | One-cycle sector completion |
| error | output | 1 | Sticky fault (status error or poll timeout) |
| ata_addr | output | 3 | Card register offset |
| ata_cs_n | output | 1 | Active-low chip select |
| ata_rd_n | output | 1 | Active-low read strobe |
| ata_wr_n | output | 1 | Active-low write strobe |
| ata_dout | output | DW | Data driven toward the card |
| ata_oe | output | 1 | Enable for the data bus driver |
| ata_din | input | DW | Data returned by the card |

## Verification
Two decisions can fall on the same status word: the busy flag and the error flag can both be set, and after the command the error flag can come with the data request. The card model in the bench returns 0x81 during early busy reads, which must not fault the sequencer. In another run it answers the post-command poll with 0x59, which must fault it before any data word is taken. Both outcomes are judged at the ports, from the count of register writes seen, the number of accepted stream words and the `error` flag. Ordinary sectors with random busy lengths, spurious data-request answers and random strobe timing run alongside these cases.

// File: rtl/sector_pkg.sv
// Shared types and constants of the storage card sector writer.
// Assumes an 8-bit task-file layout inside a 16-bit data bus.
package sector_pkg;

    // Phases of one register cycle on the card bus
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_RECOV
    } bus_phase_t;

    // Sector sequencer states
    typedef enum logic [3:0] {
        S_IDLE,
        S_POLL_PRE,
        S_SET_COUNT,
        S_SET_LBA0,
        S_SET_LBA1,
        S_SET_LBA2,
        S_SET_DEVHEAD,
        S_ISSUE,
        S_POLL_DRQ,
        S_TAKE_WORD,
        S_PUT_WORD,
        S_FAULT
    } seq_state_t;

    localparam int LBA_BITS = 28;

    // Register offsets decoded by the card
    localparam logic [2:0] OFS_DATA    = 3'd0;
    localparam logic [2:0] OFS_COUNT   = 3'd2;
    localparam logic [2:0] OFS_LBA0    = 3'd3;
    localparam logic [2:0] OFS_LBA1    = 3'd4;
    localparam logic [2:0] OFS_LBA2    = 3'd5;
    localparam logic [2:0] OFS_DEVHEAD = 3'd6;
    localparam logic [2:0] OFS_CMDSTAT = 3'd7;

    localparam logic [7:0] CMD_WRITE_SECTOR = 8'h30;
    localparam logic [7:0] DEVHEAD_LBA_MODE = 8'hE0;

    // Status bit positions
    localparam int ST_BUSY = 7;
    localparam int ST_DREQ = 3;
    localparam int ST_ERR  = 0;

endpackage

// File: rtl/ata_bus_cycle.sv
// Runs one card register cycle per request: address setup, strobe low,
// recovery with address held. Phase lengths are run-time cycle counts,
// where a value of zero is stretched to one cycle. A request is taken
// only while idle; ack is high in the last recovery cycle. Read data is
// captured at the last strobe cycle. Assumes timing inputs stay stable
// during a cycle.
module ata_bus_cycle
    import sector_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 3,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [TW-1:0] t_setup,
    input  logic [TW-1:0] t_pulse,
    input  logic [TW-1:0] t_recov,
    output logic          ack,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_cs_n,
    output logic          bus_rd_n,
    output logic          bus_wr_n,
    output logic [DW-1:0] bus_dout,
    output logic          bus_oe,
    input  logic [DW-1:0] bus_din
);

    bus_phase_t    phase;
    logic [TW-1:0] cnt;
    logic          we_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;

    function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] t);
        return (t == '0) ? TW'(1) : t;
    endfunction

    // Phase sequencing, request capture and read data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (req) begin
                        phase   <= PH_SETUP;
                        cnt     <= at_least_one(t_setup);
                        we_q    <= we;
                        addr_q  <= addr_i;
                        wdata_q <= wdata_i;
                    end
                end
                PH_SETUP: begin
                    if (cnt == TW'(1)) begin
                        phase <= PH_STROBE;
                        cnt   <= at_least_one(t_pulse);
                    end else begin
                        cnt <= cnt - TW'(1);
                    end
                end
                PH_STROBE: begin
                    if (cnt == TW'(1)) begin
                        phase <= PH_RECOV;
                        cnt   <= at_least_one(t_recov);
                        if (!we_q) rdata <= bus_din;
                    end else begin
                        cnt <= cnt - TW'(1);
                    end
                end
                PH_RECOV: begin
                    if (cnt == TW'(1)) phase <= PH_IDLE;
                    else               cnt   <= cnt - TW'(1);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Bus pin decode from the registered phase
    always_comb begin
        ack      = (phase == PH_RECOV) && (cnt == TW'(1));
        bus_addr = addr_q;
        bus_dout = wdata_q;
        bus_cs_n = (phase == PH_IDLE);
        bus_rd_n = !((phase == PH_STROBE) && !we_q);
        bus_wr_n = !((phase == PH_STROBE) && we_q);
        bus_oe   = we_q && (phase != PH_IDLE);
    end

    a_r6_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));
    a_r6_strobe_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> $past(!bus_cs_n));
    a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));
    a_r11_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> bus_oe);
    a_r11_release_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_oe);

endmodule

// File: rtl/poll_watchdog.sv
// Counts consecutive cycles in which a polling phase is active and flags
// expiry on the LIMIT-th such cycle. Any inactive cycle clears the count.
module poll_watchdog #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Saturating count of active cycles
    always_ff @(posedge clk) begin
        if (!rst_n || !active)          cnt <= '0;
        else if (cnt != CW'(LIMIT - 1)) cnt <= cnt + CW'(1);
    end

    // Expiry decode
    always_comb expired = active && (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/cf_sector_writer.sv
// Sector write sequencer for an ATA-style card in True IDE PIO mode.
// It polls status until the card is idle, loads count, address and
// device/head registers, issues the write command, polls for a data
// request and then writes WORDS stream words. A status error or a poll
// timeout faults the sequencer until reset. Assumes DW >= 8 and that
// the timing inputs are held stable while busy.
module cf_sector_writer
    import sector_pkg::*;
#(
    parameter int DW      = 16,
    parameter int WORDS   = 256,
    parameter int TIMEOUT = 4096,
    parameter int TW      = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [LBA_BITS-1:0] lba,
    input  logic [TW-1:0]       t_setup,
    input  logic [TW-1:0]       t_pulse,
    input  logic [TW-1:0]       t_recov,
    input  logic                s_valid,
    input  logic [DW-1:0]       s_data,
    output logic                s_ready,
    output logic                busy,
    output logic                done,
    output logic                error,
    output logic [2:0]          ata_addr,
    output logic                ata_cs_n,
    output logic                ata_rd_n,
    output logic                ata_wr_n,
    output logic [DW-1:0]       ata_dout,
    output logic                ata_oe,
    input  logic [DW-1:0]       ata_din
);

    localparam int CW = $clog2(WORDS + 1);

    seq_state_t          state;
    logic [LBA_BITS-1:0] lba_q;
    logic [CW-1:0]       word_cnt;
    logic [DW-1:0]       word_q;

    logic          cyc_req;
    logic          cyc_we;
    logic [2:0]    cyc_addr;
    logic [DW-1:0] cyc_wdata;
    logic          cyc_ack;
    logic [DW-1:0] cyc_rdata;
    logic [7:0]    status;
    logic          polling;
    logic          wd_expired;
    logic          last_word;
    logic          unused_hi;

    ata_bus_cycle #(.DW(DW), .AW(3), .TW(TW)) u_cycle (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (cyc_req),
        .we       (cyc_we),
        .addr_i   (cyc_addr),
        .wdata_i  (cyc_wdata),
        .t_setup  (t_setup),
        .t_pulse  (t_pulse),
        .t_recov  (t_recov),
        .ack      (cyc_ack),
        .rdata    (cyc_rdata),
        .bus_addr (ata_addr),
        .bus_cs_n (ata_cs_n),
        .bus_rd_n (ata_rd_n),
        .bus_wr_n (ata_wr_n),
        .bus_dout (ata_dout),
        .bus_oe   (ata_oe),
        .bus_din  (ata_din)
    );

    poll_watchdog #(.LIMIT(TIMEOUT)) u_watchdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (polling),
        .expired (wd_expired)
    );

    // Status byte view and helper decodes
    always_comb begin
        status    = cyc_rdata[7:0];
        unused_hi = ^cyc_rdata[DW-1:8];
        polling   = (state == S_POLL_PRE) || (state == S_POLL_DRQ);
        last_word = (word_cnt == CW'(WORDS - 1));
    end

    // Bus request selection per state
    always_comb begin
        cyc_req   = 1'b0;
        cyc_we    = 1'b0;
        cyc_addr  = OFS_CMDSTAT;
        cyc_wdata = '0;
        unique case (state)
            S_POLL_PRE, S_POLL_DRQ: cyc_req = 1'b1;
            S_SET_COUNT: begin
                cyc_req = 1'b1; cyc_we = 1'b1; cyc_addr = OFS_COUNT;
                cyc_wdata = DW'(8'd1);
            end
            S_SET_LBA0: begin
                cyc_req = 1'b1; cyc_we = 1'b1; cyc_addr = OFS_LBA0;
                cyc_wdata = DW'(lba_q[7:0]);
            end
            S_SET_LBA1: begin
                cyc_req = 1'b1; cyc_we = 1'b1; cyc_addr = OFS_LBA1;
                cyc_wdata = DW'(lba_q[15:8]);
            end
            S_SET_LBA2: begin
                cyc_req = 1'b1; cyc_we = 1'b1; cyc_addr = OFS_LBA2;
                cyc_wdata = DW'(lba_q[23:16]);
            end
            S_SET_DEVHEAD: begin
                cyc_req = 1'b1; cyc_we = 1'b1; cyc_addr = OFS_DEVHEAD;
                cyc_wdata = DW'(DEVHEAD_LBA_MODE | {4'h0, lba_q[27:24]});
            end
            S_ISSUE: begin
                cyc_req = 1'b1; cyc_we = 1'b1; cyc_addr = OFS_CMDSTAT;
                cyc_wdata = DW'(CMD_WRITE_SECTOR);
            end
            S_PUT_WORD: begin
                cyc_req = 1'b1; cyc_we = 1'b1; cyc_addr = OFS_DATA;
                cyc_wdata = word_q;
            end
            default: ;
        endcase
    end

    // Sector sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            lba_q    <= '0;
            word_cnt <= '0;
            word_q   <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        lba_q    <= lba;
                        word_cnt <= '0;
                        state    <= S_POLL_PRE;
                    end
                end
                S_POLL_PRE: begin
                    if (wd_expired) state <= S_FAULT;
                    else if (cyc_ack && !status[ST_BUSY]) begin
                        if (status[ST_ERR])        state <= S_FAULT;
                        else if (!status[ST_DREQ]) state <= S_SET_COUNT;
                    end
                end
                S_SET_COUNT:   if (cyc_ack) state <= S_SET_LBA0;
                S_SET_LBA0:    if (cyc_ack) state <= S_SET_LBA1;
                S_SET_LBA1:    if (cyc_ack) state <= S_SET_LBA2;
                S_SET_LBA2:    if (cyc_ack) state <= S_SET_DEVHEAD;
                S_SET_DEVHEAD: if (cyc_ack) state <= S_ISSUE;
                S_ISSUE:       if (cyc_ack) state <= S_POLL_DRQ;
                S_POLL_DRQ: begin
                    if (wd_expired) state <= S_FAULT;
                    else if (cyc_ack && !status[ST_BUSY]) begin
                        if (status[ST_ERR])       state <= S_FAULT;
                        else if (status[ST_DREQ]) state <= S_TAKE_WORD;
                    end
                end
                S_TAKE_WORD: begin
                    if (s_valid) begin
                        word_q <= s_data;
                        state  <= S_PUT_WORD;
                    end
                end
                S_PUT_WORD: begin
                    if (cyc_ack) begin
                        word_cnt <= word_cnt + CW'(1);
                        state    <= last_word ? S_IDLE : S_TAKE_WORD;
                    end
                end
                S_FAULT: state <= S_FAULT;
                default: state <= S_FAULT;
            endcase
        end
    end

    // Handshake and status outputs
    always_comb begin
        s_ready = (state == S_TAKE_WORD);
        busy    = (state != S_IDLE) && (state != S_FAULT);
        error   = (state == S_FAULT);
        done    = (state == S_PUT_WORD) && cyc_ack && last_word;
    end

    a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);
    a_r7_quiet_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (error && ata_cs_n) |=> ata_cs_n);
    a_r8_timeout_faults: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expired |=> error);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    a_r5_ready_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> ata_cs_n);

endmodule

// File: tb/sim_cf_sector_writer.sv
module sim_cf_sector_writer;

    localparam int DW      = 16;
    localparam int WORDS   = 256;
    localparam int TIMEOUT = 4096;
    localparam int TW      = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [27:0]   lba = '0;
    logic [TW-1:0] t_setup = 4'd1, t_pulse = 4'd1, t_recov = 4'd1;
    logic          s_valid = 1'b0;
    logic [DW-1:0] s_data = '0;
    logic          s_ready, busy, done, error;
    logic [2:0]    ata_addr;
    logic          ata_cs_n, ata_rd_n, ata_wr_n, ata_oe;
    logic [DW-1:0] ata_dout;
    logic [DW-1:0] din_r = '0;

    always #5 clk = ~clk;

    cf_sector_writer #(.DW(DW), .WORDS(WORDS), .TIMEOUT(TIMEOUT), .TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .lba(lba),
        .t_setup(t_setup), .t_pulse(t_pulse), .t_recov(t_recov),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .busy(busy), .done(done), .error(error),
        .ata_addr(ata_addr), .ata_cs_n(ata_cs_n), .ata_rd_n(ata_rd_n),
        .ata_wr_n(ata_wr_n), .ata_dout(ata_dout), .ata_oe(ata_oe),
        .ata_din(din_r)
    );

    int checks = 0, failures = 0;
    bit ended = 0;

    // Card model and expectation state
    logic [15:0] words [0:WORDS-1];
    logic [27:0] lba_cur;
    int  pre_busy, pre_drq, post_busy, post_nodrq;
    bit  noise, cmd_seen, pre_ok, post_ok;
    logic [7:0] pre_final, post_final;
    int  n_reads, n_writes;
    int  es, ep, er;
    int  ph, mcnt;
    logic [2:0] a0;
    int  sidx;
    bit  acc_pend, stream_en;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    function automatic int clampt(input int t);
        return (t == 0) ? 1 : t;
    endfunction

    function automatic logic [2:0] exp_addr(input int i);
        case (i)
            0: return 3'd2;
            1: return 3'd3;
            2: return 3'd4;
            3: return 3'd5;
            4: return 3'd6;
            5: return 3'd7;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [15:0] exp_write(input int i);
        case (i)
            0: return 16'h0001;
            1: return {8'h00, lba_cur[7:0]};
            2: return {8'h00, lba_cur[15:8]};
            3: return {8'h00, lba_cur[23:16]};
            4: return {8'h00, 4'hE, lba_cur[27:24]};
            5: return 16'h0030;
            default: return words[i-6];
        endcase
    endfunction

    task automatic model_clear();
        pre_busy = 0; pre_drq = 0; post_busy = 0; post_nodrq = 0;
        noise = 0; cmd_seen = 0; pre_ok = 0; post_ok = 0;
        pre_final = 8'h50; post_final = 8'h58;
        n_reads = 0; n_writes = 0; ph = 0; mcnt = 0;
        sidx = 0; acc_pend = 0; stream_en = 1;
    endtask

    // Bus monitor, timing measurement and card status model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                case (ph)
                    0: if (!ata_cs_n) begin ph = 1; mcnt = 1; a0 = ata_addr; end
                    1: begin
                        if (!ata_rd_n || !ata_wr_n) begin
                            chk(mcnt == es, "R6", "setup cycles", mcnt, es);
                            ph = 2; mcnt = 1;
                            if (!ata_wr_n) begin
                                chk(ata_oe, "R11", "oe on write", ata_oe, 1);
                                if (n_writes == 0)
                                    chk(pre_ok, "R2", "write before idle status", 0, 1);
                                if (n_writes == 6)
                                    chk(post_ok, "R4", "data before request", 0, 1);
                                if (n_writes < 6 + WORDS)
                                    chk(ata_addr == exp_addr(n_writes) && ata_dout == exp_write(n_writes),
                                        (n_writes < 6) ? "R3" : "R4", "write addr/data",
                                        {ata_addr, ata_dout},
                                        {exp_addr(n_writes), exp_write(n_writes)});
                                else
                                    chk(0, "R4", "extra write", n_writes, 6 + WORDS);
                                if (ata_addr == 3'd7 && ata_dout == 16'h0030) cmd_seen = 1;
                                n_writes++;
                            end else begin
                                chk(!ata_oe, "R11", "oe on read", ata_oe, 0);
                                n_reads++;
                                if (ata_addr != 3'd7) din_r = '0;
                                else if (!cmd_seen) begin
                                    if (pre_busy > 0) begin din_r = {8'h0, 7'h40, noise}; pre_busy--; end
                                    else if (pre_drq > 0) begin din_r = 16'h0058; pre_drq--; end
                                    else begin
                                        din_r = {8'h0, pre_final};
                                        if (!pre_final[7] && !pre_final[3] && !pre_final[0]) pre_ok = 1;
                                    end
                                end else begin
                                    if (post_busy > 0) begin din_r = {8'h0, 7'h40, noise}; post_busy--; end
                                    else if (post_nodrq > 0) begin din_r = 16'h0050; post_nodrq--; end
                                    else begin
                                        din_r = {8'h0, post_final};
                                        if (!post_final[7] && post_final[3] && !post_final[0]) post_ok = 1;
                                    end
                                end
                            end
                        end else mcnt++;
                    end
                    2: begin
                        if (!ata_rd_n || !ata_wr_n) begin
                            mcnt++;
                            if (ata_addr != a0) chk(0, "R6", "addr moved in strobe", ata_addr, a0);
                        end else begin
                            chk(mcnt == ep, "R6", "strobe cycles", mcnt, ep);
                            ph = 3; mcnt = 1;
                        end
                    end
                    default: begin
                        if (ata_cs_n) begin
                            chk(mcnt == er, "R6", "recovery cycles", mcnt, er);
                            ph = 0;
                        end else begin
                            mcnt++;
                            if (ata_addr != a0) chk(0, "R6", "addr moved in recovery", ata_addr, a0);
                        end
                    end
                endcase
                if (s_ready && !post_ok)
                    chk(0, "R5", "ready outside data phase", s_ready, 0);
            end
        end
    end

    // Stream source with random gaps
    initial begin
        forever begin
            @(negedge clk);
            if (acc_pend) begin sidx++; acc_pend = 0; end
            if (stream_en && sidx < WORDS) begin
                s_valid = ($urandom % 4) != 0;
                s_data  = words[sidx];
            end else s_valid = 1'b0;
            acc_pend = s_valid && s_ready;
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete");
        finish_up();
    end

    task automatic reset_dut();
        rst_n = 1'b0; start = 1'b0;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_timing(input int ts, input int tp, input int tr);
        t_setup = TW'(ts); t_pulse = TW'(tp); t_recov = TW'(tr);
        es = clampt(ts); ep = clampt(tp); er = clampt(tr);
    endtask

    task automatic pulse_start(input logic [27:0] a);
        start = 1'b1; lba = a;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_sector(input int ts, input int tp, input int tr);
        int cyc;
        int rogue_at;
        set_timing(ts, tp, tr);
        model_clear();
        lba_cur = 28'($urandom);
        for (int k = 0; k < WORDS; k++) words[k] = 16'($urandom);
        words[0] = 16'hFFFF; words[WORDS-1] = 16'h0000;
        pre_busy = $urandom % 4; pre_drq = $urandom % 3;
        post_busy = $urandom % 4; post_nodrq = $urandom % 3;
        noise = 1'($urandom);
        rogue_at = 20 + ($urandom % 200);
        pulse_start(lba_cur);
        chk(busy, "R9", "busy after start", busy, 1);
        cyc = 0;
        while (!done && cyc < 20000) begin
            if (cyc == rogue_at) begin start = 1'b1; lba = ~lba_cur; end
            else begin start = 1'b0; lba = lba_cur; end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(done, "R9", "done seen", done, 1);
        chk(n_writes == 6 + WORDS, "R10", "write count with stray start", n_writes, 6 + WORDS);
        chk(sidx == WORDS, "R5", "words taken", sidx, WORDS);
        @(negedge clk);
        chk(!done && !busy, "R9", "done single cycle, busy clear", {done, busy}, 0);
        chk(!error, "R7", "no fault on clean sector", error, 0);
    endtask

    initial begin
        int rc, wc, w0;
        void'($urandom(32'd7719));
        for (int k = 0; k < WORDS; k++) words[k] = '0;
        lba_cur = '0;
        model_clear();
        set_timing(1, 1, 1);
        reset_dut();
        // R1: reset state
        chk(ata_cs_n && ata_rd_n && ata_wr_n, "R1", "bus strobes idle",
            {ata_cs_n, ata_rd_n, ata_wr_n}, 3'b111);
        chk(!ata_oe && !s_ready && !busy && !done && !error, "R1", "outputs low",
            {ata_oe, s_ready, busy, done, error}, 0);

        // Directed timing corners, then random sectors
        run_sector(1, 1, 1);
        run_sector(0, 0, 0);
        run_sector(4, 4, 4);
        for (int n = 0; n < 3; n++)
            run_sector($urandom % 5, $urandom % 5, $urandom % 5);

        // R7: error with busy ignored, then error without busy faults before any write
        reset_dut();
        set_timing(2, 1, 1);
        pre_busy = 2; noise = 1; pre_final = 8'h51;
        pulse_start(28'h1234567);
        for (int c = 0; c < 300 && !error; c++) @(negedge clk);
        chk(error, "R7", "fault on error status", error, 1);
        chk(n_writes == 0, "R7", "no writes after error status", n_writes, 0);
        chk(n_reads == 3, "R7", "busy+error reads ignored", n_reads, 3);
        chk(!busy, "R7", "busy low in fault", busy, 0);
        repeat (20) @(negedge clk);
        rc = n_reads; wc = n_writes;
        pulse_start(28'h0);
        repeat (100) @(negedge clk);
        chk(n_reads == rc && n_writes == wc && error, "R10", "start ignored in fault",
            n_reads, rc);

        // Error together with data request after the command
        reset_dut();
        set_timing(1, 2, 1);
        lba_cur = 28'hABCDEF1;
        post_busy = 1; noise = 1; post_final = 8'h59;
        pulse_start(lba_cur);
        for (int c = 0; c < 500 && !error; c++) @(negedge clk);
        chk(error, "R7", "fault on error with request", error, 1);
        chk(n_writes == 6, "R3", "register writes before fault", n_writes, 6);
        repeat (20) @(negedge clk);
        chk(sidx == 0, "R5", "no words taken after fault", sidx, 0);

        // R8: poll timeout
        reset_dut();
        set_timing(1, 1, 1);
        pre_busy = 1 << 30;
        pulse_start(28'h0000042);
        w0 = 1;
        repeat (TIMEOUT / 2) begin @(negedge clk); w0++; end
        chk(!error, "R8", "no early timeout", error, 0);
        while (!error && w0 < 2 * TIMEOUT) begin @(negedge clk); w0++; end
        chk(error, "R8", "timeout fault", error, 1);
        chk(w0 >= TIMEOUT - 2 && w0 <= TIMEOUT + 4, "R8", "timeout cycle", w0, TIMEOUT);
        chk(n_writes == 0, "R8", "no writes after timeout", n_writes, 0);

        finish_up();
    end

endmodule